// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers up to eight peripheral interrupt lines and presents one interrupt request to a processor. Each rising edge on an input is held as a pending request. Pending requests that are not masked go through a fixed-priority resolver. That resolver also looks at the set of interrupts the processor is currently servicing. As a result, only a request that outranks everything in service raises the output, and handlers can nest.

The processor answers with two acknowledge pulses. The first pulse moves the winning request from pending to in-service. The second pulse reads an interrupt vector. The vector is an eight-aligned programmable base with the input number in its three low bits. In-service bits stay set until the processor writes an end-of-interrupt command. That command can name a level, or it can clear whichever in-service bit has the highest priority.

A parameter selects master or slave operation. A slave's request output feeds master input 2. The master signals a cascade selection during the acknowledge so that the slave supplies the vector. Every slave input therefore ranks at the level of master input 2.

Top module: `irq_hub`

## Requirements
- R1: A request is taken on the rising edge of an input. An input held high produces one request only, and only a new rising edge produces another.
- R2: While its mask bit (write select 0, data bit n for input n) is 1, an input never raises `int_o`. Its edge is still kept, and it raises `int_o` once the mask bit is cleared.
- R3: When several unmasked requests are pending, input 0 wins and input 7 loses. The lowest input number is acknowledged first.
- R4: `int_o` is high only for a request whose input number is lower than every in-service bit. An equal or lower-priority request waits, and a higher one nests.
- R5: The first acknowledge pulse moves the winning request into service. If nothing else is eligible, `int_o` is low from the next cycle.
- R6: During the second acknowledge pulse, `data_oe_o` is high for that cycle only, and `data_o` equals the base with the acknowledged input number in bits 2:0.
- R7: A base write (select 1) keeps bits 7:3 of the data and forces bits 2:0 to zero. After reset the base is 0x30 for a master and 0x38 for a slave.
- R8: Select 2 clears the in-service bit with the highest priority. Select 3 clears the in-service bit whose number is in data bits 2:0.
- R9: An in-service bit is never cleared except by an end-of-interrupt write. Time and mask or base writes leave it in place.
- R10: When a master acknowledges input 2, `cas_sel_o` is high through both pulses and the master leaves the vector undriven. A slave with `cas_en_i` high takes the request into service and drives its own vector. A slave with `cas_en_i` low does neither.
- R11: With a slave on master input 2, the overall order is master inputs 0 and 1, then slave inputs 0 to 7, then master inputs 3 to 7.
- R12: An acknowledge that finds no eligible request changes no in-service bit and returns the base plus 7.
- R13: After reset, `int_o`, `data_oe_o` and `cas_sel_o` are low and no input is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_i | input | 8 | Peripheral request lines, rising-edge sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 mask, 1 base, 2 clear top in-service, 3 clear named in-service |
| wr_data_i | input | 8 | Write data |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| cas_en_i | input | 1 | Acknowledge select: tie high on a master, connect to the master's `cas_sel_o` on a slave |
| int_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Vector, valid while `data_oe_o` is high |
| data_oe_o | output | 1 | This controller drives the vector |
| cas_sel_o | output | 1 | Master only: cascade input acknowledged |

## Verification
A request edge set up before a clock edge is latched at that edge. `int_o` is therefore due one cycle later at a master input, and two cycles later for a slave input, because the slave's output must first be latched by the master. The vector and its enable come combinationally during the second acknowledge pulse, so the bench samples them inside that pulse's cycle. Effects of the first pulse and of register writes appear from the following cycle. All inputs change on the falling clock edge, and all outputs are sampled on a falling edge or shortly after one. Every sample therefore falls at a point where the count of registers between stimulus and result is known.

// File: rtl/irq_hub_pkg.sv
// Package: shared encodings for the interrupt controller.
// Assumes an eight-bit vector and at most eight request lines per controller.
package irq_hub_pkg;

    // Register write selects.
    typedef enum logic [1:0] {
        REG_MASK    = 2'd0,
        REG_BASE    = 2'd1,
        REG_EOI_TOP = 2'd2,
        REG_EOI_LVL = 2'd3
    } reg_sel_e;

    // Acknowledge handshake phase.
    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_WAIT2 = 1'b1
    } ack_state_e;

    localparam logic [7:0] MASTER_BASE = 8'h30;
    localparam logic [7:0] SLAVE_BASE  = 8'h38;

endpackage

// File: rtl/irq_first_set.sv
// Finds the lowest-numbered set bit (highest priority) in a vector.
// Assumes priority falls as the index rises; idx_o is 0 when nothing is set.
module irq_first_set #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Scan from the lowest priority upward so the top bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        any_o = |vec_i;
    end

endmodule

// File: rtl/irq_req_latch.sv
// Rising-edge detector and pending-request register.
// Assumes inputs are already synchronous to clk; a new edge wins over a same-cycle clear.
module irq_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] rise;

    assign rise  = irq_i & ~prev_q;
    assign irr_o = irr_q;

    // Remember last cycle's input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_i;
    end

    // Hold pending requests until the acknowledge takes them.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= (irr_q & ~clr_i) | rise;
    end

    assert_edge_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> (irr_q != '0));

    assert_only_edges_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (irr_q & ~$past(irr_q) & ~$past(rise)) == '0);

endmodule

// File: rtl/irq_prio_resolver.sv
// Fixed-priority resolver: picks the best unmasked pending request that
// outranks every in-service bit. Assumes index 0 is highest priority.
module irq_prio_resolver #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  isr_i,
    output logic          grant_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] blocked;
    logic [N-1:0] eligible;

    // An input is blocked when any in-service bit at its level or above is set.
    for (genvar g = 0; g < N; g++) begin : g_block
        assign blocked[g] = |isr_i[g:0];
    end

    assign eligible = irr_i & ~mask_i & ~blocked;

    irq_first_set #(.N(N), .IW(IW)) pick_i (
        .vec_i (eligible),
        .any_o (grant_o),
        .idx_o (idx_o)
    );

endmodule

// File: rtl/irq_ack_seq.sv
// Two-pulse acknowledge sequencer and vector driver.
// Assumes inta_i is high for exactly one cycle per pulse. The master flags the
// cascade input so the slave drives the vector instead.
module irq_ack_seq
    import irq_hub_pkg::*;
#(
    parameter int N           = 8,
    parameter int IW          = $clog2(N),
    parameter int VEC_W       = 8,
    parameter bit IS_SLAVE    = 1'b0,
    parameter int CASCADE_IDX = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inta_i,
    input  logic                cas_en_i,
    input  logic                grant_i,
    input  logic [IW-1:0]       grant_idx_i,
    input  logic [VEC_W-IW-1:0] base_hi_i,
    output logic                commit_o,
    output logic [VEC_W-1:0]    data_o,
    output logic                data_oe_o,
    output logic                cas_sel_o
);

    ack_state_e    state_q;
    logic          sel_q;
    logic [IW-1:0] idx_q;
    logic          to_cascade;

    assign commit_o = (state_q == ACK_IDLE) && inta_i && cas_en_i && grant_i;

    // Track pulse phase and latch the chosen input on the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            sel_q   <= 1'b0;
            idx_q   <= '0;
        end else if (inta_i) begin
            if (state_q == ACK_IDLE) begin
                state_q <= ACK_WAIT2;
                sel_q   <= cas_en_i;
                idx_q   <= grant_i ? grant_idx_i : IW'(N - 1);
            end else begin
                state_q <= ACK_IDLE;
            end
        end
    end

    // The master decides on cascade handling; a slave never flags it.
    if (IS_SLAVE) begin : g_slave
        assign to_cascade = 1'b0;
        assign cas_sel_o  = 1'b0;
    end else begin : g_master
        assign to_cascade = (idx_q == IW'(CASCADE_IDX));
        assign cas_sel_o  = ((state_q == ACK_IDLE) && inta_i && cas_en_i && grant_i
                             && (grant_idx_i == IW'(CASCADE_IDX)))
                          || ((state_q == ACK_WAIT2) && sel_q && to_cascade);
    end

    // Drive the vector on the second pulse when this controller owns it.
    always_comb begin
        data_oe_o = (state_q == ACK_WAIT2) && inta_i && sel_q && !to_cascade;
        data_o    = data_oe_o ? {base_hi_i, idx_q} : '0;
    end

    assert_oe_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |=> !data_oe_o);

    assert_commit_opens_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (state_q == ACK_WAIT2));

    assert_cascade_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_sel_o && state_q == ACK_WAIT2) |-> !data_oe_o);

endmodule

// File: rtl/irq_hub.sv
// Top: eight-input priority interrupt controller, master or slave.
// Holds the mask, vector base and in-service registers and handles the
// end-of-interrupt commands. Assumes N_IRQ <= VEC_W and requests synchronous to clk.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int VEC_W       = 8,
    parameter bit IS_SLAVE    = 1'b0,
    parameter int CASCADE_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [VEC_W-1:0] wr_data_i,
    input  logic             inta_i,
    input  logic             cas_en_i,
    output logic             int_o,
    output logic [VEC_W-1:0] data_o,
    output logic             data_oe_o,
    output logic             cas_sel_o
);

    localparam int IDX_W  = $clog2(N_IRQ);
    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [VEC_W-1:0] RESET_BASE = IS_SLAVE ? VEC_W'(SLAVE_BASE)
                                                       : VEC_W'(MASTER_BASE);

    logic [N_IRQ-1:0]  irr;
    logic [N_IRQ-1:0]  mask_q;
    logic [N_IRQ-1:0]  isr_q;
    logic [N_IRQ-1:0]  isr_set;
    logic [N_IRQ-1:0]  isr_clr;
    logic [BASE_W-1:0] base_hi_q;
    logic              grant;
    logic [IDX_W-1:0]  grant_idx;
    logic              commit;
    logic              isr_any;
    logic [IDX_W-1:0]  isr_top_idx;

    irq_req_latch #(.N(N_IRQ)) req_i (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_i),
        .clr_i (isr_set),
        .irr_o (irr)
    );

    irq_prio_resolver #(.N(N_IRQ), .IW(IDX_W)) prio_i (
        .irr_i   (irr),
        .mask_i  (mask_q),
        .isr_i   (isr_q),
        .grant_o (grant),
        .idx_o   (grant_idx)
    );

    irq_first_set #(.N(N_IRQ), .IW(IDX_W)) isr_top_i (
        .vec_i (isr_q),
        .any_o (isr_any),
        .idx_o (isr_top_idx)
    );

    irq_ack_seq #(
        .N           (N_IRQ),
        .IW          (IDX_W),
        .VEC_W       (VEC_W),
        .IS_SLAVE    (IS_SLAVE),
        .CASCADE_IDX (CASCADE_IDX)
    ) ack_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .inta_i      (inta_i),
        .cas_en_i    (cas_en_i),
        .grant_i     (grant),
        .grant_idx_i (grant_idx),
        .base_hi_i   (base_hi_q),
        .commit_o    (commit),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .cas_sel_o   (cas_sel_o)
    );

    assign int_o = grant;

    // Mask and vector base written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            base_hi_q <= RESET_BASE[VEC_W-1:IDX_W];
        end else if (wr_en_i) begin
            if (wr_sel_i == REG_MASK) mask_q    <= wr_data_i[N_IRQ-1:0];
            if (wr_sel_i == REG_BASE) base_hi_q <= wr_data_i[VEC_W-1:IDX_W];
        end
    end

    // Work out which in-service bits to set (acknowledge) and clear (EOI).
    always_comb begin
        isr_set = commit ? (N_IRQ'(1) << grant_idx) : '0;
        isr_clr = '0;
        if (wr_en_i && wr_sel_i == REG_EOI_TOP && isr_any)
            isr_clr = N_IRQ'(1) << isr_top_idx;
        if (wr_en_i && wr_sel_i == REG_EOI_LVL)
            isr_clr = N_IRQ'(1) << wr_data_i[IDX_W-1:0];
    end

    // In-service register update.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | isr_set;
    end

    assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !mask_q[grant_idx]);

    assert_nest_higher_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && isr_any) |-> (grant_idx < isr_top_idx));

    assert_single_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);

    assert_isr_needs_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(isr_q) & ~isr_q) != '0) |-> $past(wr_en_i && wr_sel_i[1]));

endmodule

// File: tb/irq_hub_tb_top.sv
// Directed bench: a master with a slave on its input 2. Inputs change on the
// falling clock edge, and outputs are sampled on falling edges.
module irq_hub_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_irq = '0;
    logic [7:0] s_irq = '0;
    logic       m_wr = 1'b0;
    logic       s_wr = 1'b0;
    logic [1:0] wsel = '0;
    logic [7:0] wdat = '0;
    logic       inta = 1'b0;
    logic       m_int, s_int, m_oe, s_oe, m_cas, s_cas;
    logic [7:0] m_data, s_data;
    logic [7:0] m_lines;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign m_lines = {m_irq[7:3], s_int, m_irq[1:0]};

    irq_hub #(.IS_SLAVE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(m_lines), .wr_en_i(m_wr), .wr_sel_i(wsel),
        .wr_data_i(wdat), .inta_i(inta), .cas_en_i(1'b1), .int_o(m_int),
        .data_o(m_data), .data_oe_o(m_oe), .cas_sel_o(m_cas));

    irq_hub #(.IS_SLAVE(1'b1)) slave_i (
        .clk(clk), .rst_n(rst_n), .irq_i(s_irq), .wr_en_i(s_wr), .wr_sel_i(wsel),
        .wr_data_i(wdat), .inta_i(inta), .cas_en_i(m_cas), .int_o(s_int),
        .data_o(s_data), .data_oe_o(s_oe), .cas_sel_o(s_cas));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // who: 0 master, 1 slave
    task automatic wr(input bit who, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wsel = sel; wdat = d;
        if (who) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic pulse(input bit who, input logic [7:0] bits);
        @(negedge clk);
        if (who) s_irq = s_irq | bits; else m_irq = m_irq | bits;
        @(negedge clk);
        if (who) s_irq = s_irq & ~bits; else m_irq = m_irq & ~bits;
    endtask

    // Two acknowledge pulses; returns the bus vector and what was seen.
    task automatic ack(output logic [7:0] vec, output logic moe, output logic soe,
                       output logic cas, output logic int_mid);
        @(negedge clk);
        inta = 1'b1;
        #1 cas = m_cas;
        @(negedge clk);
        inta = 1'b0;
        int_mid = m_int;
        @(negedge clk);
        inta = 1'b1;
        #1 moe = m_oe; soe = s_oe;
        vec = m_oe ? m_data : s_data;
        @(negedge clk);
        inta = 1'b0;
    endtask

    logic [7:0] v;
    logic moe, soe, cas, mid;

    task automatic t_reset();
        check("R13 int", m_int, 0);
        check("R13 oe", m_oe | s_oe, 0);
        check("R13 cas", m_cas, 0);
    endtask

    task automatic t_basic();
        pulse(0, 8'h10);
        check("R1 edge raises int", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R5 int drops after first pulse", mid, 0);
        check("R6 R7 vector 0x34", v, 8'h34);
        check("R6 master drives", {moe, soe}, 2'b10);
        tick(1);
        check("R6 oe one cycle", m_oe, 0);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_prio();
        pulse(0, 8'h42);
        ack(v, moe, soe, cas, mid);
        check("R3 input 1 first", v, 8'h31);
        check("R4 lower waits", mid, 0);
        wr(0, 2'd2, 8'h00);
        check("R8 top EOI releases", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R3 input 6 next", v, 8'h36);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_nest();
        pulse(0, 8'h20);
        ack(v, moe, soe, cas, mid);
        check("R6 vector 0x35", v, 8'h35);
        pulse(0, 8'h40);
        check("R4 lower blocked", m_int, 0);
        pulse(0, 8'h08);
        check("R4 higher nests", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R4 nested vector", v, 8'h33);
        wr(0, 2'd2, 8'h00);
        check("R8 top EOI cleared 3 only", m_int, 0);
        wr(0, 2'd3, 8'h05);
        check("R8 named EOI cleared 5", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R4 waiting 6 served", v, 8'h36);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_mask();
        wr(0, 2'd0, 8'h10);
        pulse(0, 8'h10);
        tick(3);
        check("R2 masked no int", m_int, 0);
        wr(0, 2'd0, 8'h00);
        check("R2 unmask raises kept edge", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R2 vector", v, 8'h34);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_level();
        @(negedge clk);
        m_irq[7] = 1'b1;
        @(negedge clk);
        check("R1 level edge", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R1 vector", v, 8'h37);
        wr(0, 2'd2, 8'h00);
        tick(3);
        check("R1 held level no repeat", m_int, 0);
        m_irq[7] = 1'b0;
        tick(1);
        m_irq[7] = 1'b1;
        tick(1);
        check("R1 new edge", m_int, 1);
        ack(v, moe, soe, cas, mid);
        wr(0, 2'd2, 8'h00);
        m_irq[7] = 1'b0;
    endtask

    task automatic t_base();
        wr(0, 2'd1, 8'h5F);
        pulse(0, 8'h02);
        ack(v, moe, soe, cas, mid);
        check("R7 base low bits forced", v, 8'h59);
        wr(0, 2'd2, 8'h00);
        wr(0, 2'd1, 8'h30);
    endtask

    task automatic t_noclr();
        pulse(0, 8'h01);
        ack(v, moe, soe, cas, mid);
        tick(20);
        wr(0, 2'd0, 8'h00);
        wr(0, 2'd1, 8'h30);
        pulse(0, 8'h01);
        check("R9 in-service persists", m_int, 0);
        wr(0, 2'd2, 8'h00);
        check("R9 EOI releases", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R9 vector", v, 8'h30);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_cascade();
        pulse(1, 8'h08);
        tick(1);
        check("R10 slave reaches master", m_int, 1);
        ack(v, moe, soe, cas, mid);
        check("R10 cascade flagged", cas, 1);
        check("R10 slave drives", {moe, soe}, 2'b01);
        check("R10 R7 slave vector", v, 8'h3B);
        wr(1, 2'd2, 8'h00);
        wr(0, 2'd2, 8'h00);
        check("R10 idle after EOIs", m_int, 0);
    endtask

    task automatic t_order();
        @(negedge clk);
        m_irq[5] = 1'b1; s_irq[0] = 1'b1;
        @(negedge clk);
        m_irq[5] = 1'b0; s_irq[0] = 1'b0;
        tick(1);
        ack(v, moe, soe, cas, mid);
        check("R11 slave over master 5", v, 8'h38);
        check("R11 master 5 waits", mid, 0);
        wr(1, 2'd2, 8'h00);
        wr(0, 2'd2, 8'h00);
        ack(v, moe, soe, cas, mid);
        check("R11 master 5 after", v, 8'h35);
        wr(0, 2'd2, 8'h00);
        @(negedge clk);
        m_irq[1] = 1'b1; s_irq[6] = 1'b1;
        @(negedge clk);
        m_irq[1] = 1'b0; s_irq[6] = 1'b0;
        tick(1);
        ack(v, moe, soe, cas, mid);
        check("R11 master 1 over slave", v, 8'h31);
        wr(0, 2'd2, 8'h00);
        ack(v, moe, soe, cas, mid);
        check("R11 slave 6 next", v, 8'h3E);
        wr(1, 2'd2, 8'h00);
        wr(0, 2'd2, 8'h00);
    endtask

    task automatic t_spurious();
        ack(v, moe, soe, cas, mid);
        check("R12 spurious vector", v, 8'h37);
        check("R12 master drives", {moe, soe}, 2'b10);
        pulse(0, 8'h80);
        check("R12 no in-service set", m_int, 1);
        ack(v, moe, soe, cas, mid);
        wr(0, 2'd2, 8'h00);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_basic();
        t_prio();
        t_nest();
        t_mask();
        t_level();
        t_base();
        t_noclr();
        t_cascade();
        t_order();
        t_spurious();
        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule